// File: doc/BRIEF.md
# Serial Wiper Command Decoder

This block is the command front end of a four-channel digital potentiometer. It receives a serial stream (SPI mode 0: data captured on the rising edge of SCK, returned on the falling edge) and splits each chip-select frame into three parts: a device identification byte, an instruction byte, and a data byte when the command needs one. It turns every accepted command into a single-cycle strobe toward the wiper and data-register storage. That storage lives outside this block. For read commands the block fetches the value through a request and shifts it back to the host.

The serial pins are brought into a faster system clock through synchronizer stages. Edges of SCK are detected in that clock domain. A hold input can pause a frame in the middle without losing its place. Two strap pins give each device its own bus address, so up to four devices can share one bus. A frame with the wrong identity, or with an undefined opcode, is dropped silently until chip select goes high.

Top module: `spi_wiper_cmd`

## Requirements
- R1: The first byte of a frame must equal 0101 00 followed by the two strap bits on `addr_i`. Any other first byte produces no strobe and no drive on SO for the rest of that frame.
- R2: The instruction byte is laid out as opcode[7:4], register[3:2], channel[1:0]. The four copy commands strobe `cmd_stb_o` once, right after the instruction byte, with these `cmd_o` codes:
  - 1101 gives 3 (data register to wiper).
  - 1110 gives 4 (wiper to data register).
  - 0001 with channel 00 gives 5 (all data registers to all wipers).
  - 1000 with channel 00 gives 6 (all wipers to all data registers).
- R3: The two write commands strobe `cmd_stb_o` after the third byte, with `data_o` set to that byte's six low bits. Opcode 1010 with register 00 gives code 1 (write wiper). Opcode 1100 gives code 2 (write data register).
- R4: Opcode 1001 with register 00 (read wiper) and opcode 1011 (read data register) pulse `rd_req_o` after the instruction byte. `rd_dreg_o` is 0 for a wiper read and 1 for a data-register read. The third byte is then driven on SO, MSB first, as 00 followed by `rd_data_i`. SO changes only after falling SCK edges, and `so_oe_o` stays high through all eight bits.
- R5: The exact instruction byte 0101 0001 returns the byte 0000000 followed by `busy_i` on SO.
- R6: After opcode 0010, every later SCK rising edge gives one `step_stb_o` pulse, with `step_up_o` equal to SI at that edge. This continues until chip select rises.
- R7: While HOLD is taken low with SCK low, SCK edges are ignored and SO is released. Taking HOLD high again with SCK low resumes the frame at the bit where it stopped.
- R8: After reset, no frame is accepted until chip select has been seen high at least once.
- R9: Any other opcode, or a global copy with a nonzero channel field, produces no strobe and no SO drive for the rest of the frame.
- R10: `so_oe_o` is low out of reset, and again once chip select is high.
- R11: Each strobe lasts one clock, and at most one of `cmd_stb_o`, `step_stb_o`, `rd_req_o` is high in any cycle. Each strobe appears SYNC_STAGES+1 clocks after the SCK edge that completes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCK |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock |
| cs_n_i | input | 1 | Chip select, active low |
| si_i | input | 1 | Serial data from host |
| hold_n_i | input | 1 | Pause request, active low |
| addr_i | input | 2 | Strapped device address |
| so_o | output | 1 | Serial data to host |
| so_oe_o | output | 1 | Drive enable for SO (low means high impedance) |
| cmd_stb_o | output | 1 | One-cycle strobe for a write or copy command |
| cmd_o | output | 3 | Command code, valid with `cmd_stb_o` |
| chan_o | output | 2 | Channel field of the current instruction |
| reg_o | output | 2 | Register field of the current instruction |
| data_o | output | 6 | Write value, valid with `cmd_stb_o` |
| step_stb_o | output | 1 | One-cycle wiper step strobe |
| step_up_o | output | 1 | Step direction, 1 means up |
| rd_req_o | output | 1 | One-cycle read request |
| rd_dreg_o | output | 1 | Read source: 1 is data register, 0 is wiper |
| rd_data_i | input | 6 | Read value, valid from the cycle after `rd_req_o` |
| busy_i | input | 1 | Storage write in progress, returned by status read |

## Verification
Every strobe is due exactly SYNC_STAGES+1 clocks after the clock-domain edge on which the bench changes SCK. The bench timestamps each rising SCK edge and requires each strobe to land in that exact cycle. Read-back bits reach SO a few clocks after each falling edge. Each SCK phase lasts six clocks, so the bench samples SO just before the following rising edge, when every bit has settled. A reference queue holds the command, step and read request that each frame should produce, and a monitor compares every strobe against it on every clock.

// File: rtl/wiper_cmd_pkg.sv
package wiper_cmd_pkg;
  typedef enum logic [2:0] {
    OP_NONE       = 3'd0,
    OP_SET_WIPER  = 3'd1,
    OP_SET_DREG   = 3'd2,
    OP_DREG2WIPER = 3'd3,
    OP_WIPER2DREG = 3'd4,
    OP_ALL_D2W    = 3'd5,
    OP_ALL_W2D    = 3'd6
  } op_e;

  typedef enum logic [2:0] {
    FR_ID, FR_INSTR, FR_WDATA, FR_RDATA, FR_STEP, FR_SKIP
  } frame_e;

  localparam logic [3:0] OPC_RD_WIPER = 4'b1001;
  localparam logic [3:0] OPC_WR_WIPER = 4'b1010;
  localparam logic [3:0] OPC_RD_DREG  = 4'b1011;
  localparam logic [3:0] OPC_WR_DREG  = 4'b1100;
  localparam logic [3:0] OPC_D2W      = 4'b1101;
  localparam logic [3:0] OPC_W2D      = 4'b1110;
  localparam logic [3:0] OPC_ALL_D2W  = 4'b0001;
  localparam logic [3:0] OPC_ALL_W2D  = 4'b1000;
  localparam logic [3:0] OPC_STEP     = 4'b0010;
  localparam logic [7:0] INSTR_STATUS = 8'b0101_0001;
endpackage

// File: rtl/wcd_sync.sv
module wcd_sync #(
  parameter int              WIDTH   = 4,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= RST_VAL;
    else        stg_q[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= RST_VAL;
      else        stg_q[s] <= stg_q[s-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/wcd_frame.sv
module wcd_frame
  import wiper_cmd_pkg::*;
#(
  parameter int         DW       = 6,
  parameter logic [3:0] DEV_TYPE = 4'b0101
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_s,
  input  logic          cs_n_s,
  input  logic          si_s,
  input  logic          hold_n_s,
  input  logic [1:0]    addr_i,
  output logic          frame_on,
  output logic          hold_act,
  output logic          armed,
  output logic          tx_load,
  output logic          tx_shift,
  output logic          tx_clr,
  output logic          cmd_stb,
  output logic [2:0]    cmd,
  output logic [1:0]    chan,
  output logic [1:0]    rsel,
  output logic [DW-1:0] data,
  output logic          step_stb,
  output logic          step_up,
  output logic          rd_req,
  output logic          rd_dreg,
  output logic          rd_status
);
  frame_e      st_q, st_d;
  logic [2:0]  cnt_q, cnt_d;
  logic [6:0]  sh_q, sh_d;
  logic        sck_q, hold_q, armed_q;
  op_e         op_q, op_d;
  logic [1:0]  chan_q, chan_d, rsel_q, rsel_d;
  logic [DW-1:0] data_q, data_d;
  logic        cmd_stb_q, cmd_stb_d, step_stb_q, step_stb_d, step_up_q, step_up_d;
  logic        rd_req_q, rd_req_d, rd_dreg_q, rd_dreg_d, rd_st_q, rd_st_d;

  logic       go, rise, fall, last;
  logic [7:0] byte_now;
  logic [3:0] opc;
  logic [1:0] rs, ps;

  assign frame_on = armed_q & ~cs_n_s;
  assign go       = frame_on & ~hold_q;
  assign rise     = go & sck_s & ~sck_q;
  assign fall     = go & ~sck_s & sck_q;
  assign last     = (cnt_q == 3'd7);
  assign byte_now = {sh_q, si_s};
  assign opc      = byte_now[7:4];
  assign rs       = byte_now[3:2];
  assign ps       = byte_now[1:0];

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; sh_d = sh_q; op_d = op_q;
    chan_d = chan_q; rsel_d = rsel_q; data_d = data_q;
    rd_dreg_d = rd_dreg_q; rd_st_d = rd_st_q; step_up_d = step_up_q;
    cmd_stb_d = 1'b0; step_stb_d = 1'b0; rd_req_d = 1'b0;
    if (!frame_on) begin
      st_d = FR_ID; cnt_d = 3'd0; op_d = OP_NONE; rd_st_d = 1'b0;
    end else if (rise) begin
      cnt_d = cnt_q + 3'd1;
      sh_d  = byte_now[6:0];
      case (st_q)
        FR_ID: if (last)
          st_d = (byte_now == {DEV_TYPE, 2'b00, addr_i}) ? FR_INSTR : FR_SKIP;
        FR_INSTR: if (last) begin
          chan_d = ps; rsel_d = rs; st_d = FR_SKIP; op_d = OP_NONE;
          if (byte_now == INSTR_STATUS) begin
            rd_st_d = 1'b1; st_d = FR_RDATA;
          end else begin
            case (opc)
              OPC_RD_WIPER: if (rs == 2'b00) begin
                rd_req_d = 1'b1; rd_dreg_d = 1'b0; st_d = FR_RDATA;
              end
              OPC_RD_DREG: begin
                rd_req_d = 1'b1; rd_dreg_d = 1'b1; st_d = FR_RDATA;
              end
              OPC_WR_WIPER: if (rs == 2'b00) begin
                op_d = OP_SET_WIPER; st_d = FR_WDATA;
              end
              OPC_WR_DREG: begin op_d = OP_SET_DREG; st_d = FR_WDATA; end
              OPC_D2W: begin op_d = OP_DREG2WIPER; cmd_stb_d = 1'b1; end
              OPC_W2D: begin op_d = OP_WIPER2DREG; cmd_stb_d = 1'b1; end
              OPC_ALL_D2W: if (ps == 2'b00) begin
                op_d = OP_ALL_D2W; cmd_stb_d = 1'b1;
              end
              OPC_ALL_W2D: if (ps == 2'b00) begin
                op_d = OP_ALL_W2D; cmd_stb_d = 1'b1;
              end
              OPC_STEP: st_d = FR_STEP;
              default: ;
            endcase
          end
        end
        FR_WDATA: if (last) begin
          cmd_stb_d = 1'b1; data_d = byte_now[DW-1:0]; st_d = FR_SKIP;
        end
        FR_RDATA: if (last) st_d = FR_SKIP;
        FR_STEP: begin step_stb_d = 1'b1; step_up_d = si_s; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0; hold_q <= 1'b0; armed_q <= 1'b0;
      st_q <= FR_ID; cnt_q <= 3'd0; sh_q <= '0; op_q <= OP_NONE;
      chan_q <= '0; rsel_q <= '0; data_q <= '0;
      cmd_stb_q <= 1'b0; step_stb_q <= 1'b0; step_up_q <= 1'b0;
      rd_req_q <= 1'b0; rd_dreg_q <= 1'b0; rd_st_q <= 1'b0;
    end else begin
      sck_q <= sck_s;
      if (cs_n_s) armed_q <= 1'b1;
      if (cs_n_s)      hold_q <= 1'b0;
      else if (!sck_s) hold_q <= ~hold_n_s;
      st_q <= st_d; cnt_q <= cnt_d; sh_q <= sh_d; op_q <= op_d;
      chan_q <= chan_d; rsel_q <= rsel_d; data_q <= data_d;
      cmd_stb_q <= cmd_stb_d; step_stb_q <= step_stb_d; step_up_q <= step_up_d;
      rd_req_q <= rd_req_d; rd_dreg_q <= rd_dreg_d; rd_st_q <= rd_st_d;
    end
  end

  assign hold_act  = hold_q;
  assign armed     = armed_q;
  assign tx_load   = fall & (st_q == FR_RDATA) & (cnt_q == 3'd0);
  assign tx_shift  = fall & (st_q == FR_RDATA) & (cnt_q != 3'd0);
  assign tx_clr    = (st_q != FR_RDATA);
  assign cmd_stb   = cmd_stb_q;
  assign cmd       = op_q;
  assign chan      = chan_q;
  assign rsel      = rsel_q;
  assign data      = data_q;
  assign step_stb  = step_stb_q;
  assign step_up   = step_up_q;
  assign rd_req    = rd_req_q;
  assign rd_dreg   = rd_dreg_q;
  assign rd_status = rd_st_q;
endmodule

// File: rtl/wcd_tx.sv
module wcd_tx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic         clr,
  input  logic [W-1:0] value,
  output logic         so,
  output logic         live
);
  logic [W-1:0] sh_q;
  logic         live_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      live_q <= 1'b0;
    end else begin
      if (load)       sh_q <= value;
      else if (shift) sh_q <= {sh_q[W-2:0], 1'b0};
      if (clr)        live_q <= 1'b0;
      else if (load)  live_q <= 1'b1;
    end
  end

  assign so   = sh_q[W-1];
  assign live = live_q;
endmodule

// File: rtl/spi_wiper_cmd.sv
module spi_wiper_cmd #(
  parameter int         SYNC_STAGES = 2,
  parameter int         DW          = 6,
  parameter logic [3:0] DEV_TYPE    = 4'b0101
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck_i,
  input  logic          cs_n_i,
  input  logic          si_i,
  input  logic          hold_n_i,
  input  logic [1:0]    addr_i,
  output logic          so_o,
  output logic          so_oe_o,
  output logic          cmd_stb_o,
  output logic [2:0]    cmd_o,
  output logic [1:0]    chan_o,
  output logic [1:0]    reg_o,
  output logic [DW-1:0] data_o,
  output logic          step_stb_o,
  output logic          step_up_o,
  output logic          rd_req_o,
  output logic          rd_dreg_o,
  input  logic [DW-1:0] rd_data_i,
  input  logic          busy_i
);
  localparam int BYTE_W = 8;
  localparam int PAD_W  = BYTE_W - DW;

  logic [3:0] pins_s;
  logic frame_on, hold_act, armed, tx_load, tx_shift, tx_clr, rd_status, tx_live;
  logic [BYTE_W-1:0] tx_value;

  wcd_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({hold_n_i, si_i, cs_n_i, sck_i}), .q(pins_s)
  );

  wcd_frame #(.DW(DW), .DEV_TYPE(DEV_TYPE)) u_frame (
    .clk(clk), .rst_n(rst_n),
    .sck_s(pins_s[0]), .cs_n_s(pins_s[1]), .si_s(pins_s[2]), .hold_n_s(pins_s[3]),
    .addr_i(addr_i), .frame_on(frame_on), .hold_act(hold_act), .armed(armed),
    .tx_load(tx_load), .tx_shift(tx_shift), .tx_clr(tx_clr),
    .cmd_stb(cmd_stb_o), .cmd(cmd_o), .chan(chan_o), .rsel(reg_o), .data(data_o),
    .step_stb(step_stb_o), .step_up(step_up_o),
    .rd_req(rd_req_o), .rd_dreg(rd_dreg_o), .rd_status(rd_status)
  );

  assign tx_value = rd_status ? {{(BYTE_W-1){1'b0}}, busy_i} : {{PAD_W{1'b0}}, rd_data_i};

  wcd_tx #(.W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .shift(tx_shift), .clr(tx_clr),
    .value(tx_value), .so(so_o), .live(tx_live)
  );

  assign so_oe_o = tx_live & ~hold_act & frame_on;
endmodule

// File: rtl/wiper_cmd_chk.sv
module wiper_cmd_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_stb,
  input logic step_stb,
  input logic rd_req,
  input logic frame_on,
  input logic hold_act,
  input logic armed
);
  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_stb, step_stb, rd_req}));

  // R11
  cmd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb);

  // R8
  unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !(cmd_stb || step_stb || rd_req));

  // R7
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_act |-> !(cmd_stb || step_stb || rd_req));

  // R2
  cmd_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> $past(frame_on));
endmodule

bind spi_wiper_cmd wiper_cmd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb_o), .step_stb(step_stb_o),
  .rd_req(rd_req_o), .frame_on(frame_on), .hold_act(hold_act), .armed(armed)
);

// File: tb/tb_spi_wiper_cmd.sv
module tb_spi_wiper_cmd;
  localparam int CLK_PERIOD = 10;
  localparam int H = 6;
  localparam int LAT = 3;
  localparam logic [1:0] MY_ADDR = 2'b10;

  logic clk, rst_n, sck, cs_n, si, hold_n, busy;
  logic [1:0] addr;
  logic so_o, so_oe_o, cmd_stb_o, step_stb_o, step_up_o, rd_req_o, rd_dreg_o;
  logic [2:0] cmd_o;
  logic [1:0] chan_o, reg_o;
  logic [5:0] data_o, rd_data_i;

  logic [5:0] wiper_mem [4];
  logic [5:0] dreg_mem [4][4];

  int errors = 0, checks = 0, cyc = 0, rise_cyc = 0;
  string tag = "R10";
  logic [12:0] exp_cmd [$];
  logic [2:0]  exp_step [$];
  logic [4:0]  exp_rd [$];
  logic [12:0] e_cmd;
  logic [2:0]  e_step;
  logic [4:0]  e_rd;
  logic        done = 1'b0;

  spi_wiper_cmd dut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .cs_n_i(cs_n), .si_i(si), .hold_n_i(hold_n),
    .addr_i(addr), .so_o(so_o), .so_oe_o(so_oe_o), .cmd_stb_o(cmd_stb_o), .cmd_o(cmd_o),
    .chan_o(chan_o), .reg_o(reg_o), .data_o(data_o), .step_stb_o(step_stb_o),
    .step_up_o(step_up_o), .rd_req_o(rd_req_o), .rd_dreg_o(rd_dreg_o),
    .rd_data_i(rd_data_i), .busy_i(busy)
  );

  assign rd_data_i = rd_dreg_o ? dreg_mem[chan_o][reg_o] : wiper_mem[chan_o];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference comparison on every clock
  always @(negedge clk) if (rst_n && !done) begin
    if (cmd_stb_o) begin
      if (exp_cmd.size() == 0)
        chk(1'b0, tag, "unexpected cmd strobe", {19'd0, cmd_o, chan_o, reg_o, data_o}, 32'd0);
      else begin
        e_cmd = exp_cmd.pop_front();
        chk({cmd_o, chan_o, reg_o, data_o} == e_cmd, tag, "cmd fields",
            {19'd0, cmd_o, chan_o, reg_o, data_o}, {19'd0, e_cmd});
      end
      chk(cyc == rise_cyc + LAT, "R11", "cmd latency", cyc, rise_cyc + LAT);
    end
    if (step_stb_o) begin
      if (exp_step.size() == 0)
        chk(1'b0, tag, "unexpected step strobe", {29'd0, step_up_o, chan_o}, 32'd0);
      else begin
        e_step = exp_step.pop_front();
        chk({step_up_o, chan_o} == e_step, "R6", "step fields",
            {29'd0, step_up_o, chan_o}, {29'd0, e_step});
      end
      chk(cyc == rise_cyc + LAT, "R11", "step latency", cyc, rise_cyc + LAT);
    end
    if (rd_req_o) begin
      if (exp_rd.size() == 0)
        chk(1'b0, tag, "unexpected read request", {27'd0, rd_dreg_o, chan_o, reg_o}, 32'd0);
      else begin
        e_rd = exp_rd.pop_front();
        chk({rd_dreg_o, chan_o, reg_o} == e_rd, "R4", "read request fields",
            {27'd0, rd_dreg_o, chan_o, reg_o}, {27'd0, e_rd});
      end
    end
  end

  task automatic wait_h();
    repeat (H) @(negedge clk);
  endtask

  task automatic xfer_bit(input logic b, output logic so_s, output logic oe_s);
    si = b;
    wait_h();
    so_s = so_o;
    oe_s = so_oe_o;
    sck = 1'b1;
    rise_cyc = cyc;
    wait_h();
    sck = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic [7:0] rx,
                           output logic oe_all, output logic oe_any);
    logic s, o;
    oe_all = 1'b1;
    oe_any = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      xfer_bit(b[i], s, o);
      rx[i] = s;
      oe_all = oe_all & o;
      oe_any = oe_any | o;
    end
  endtask

  task automatic cs_low();
    cs_n = 1'b0;
    wait_h();
  endtask

  task automatic cs_high();
    wait_h();
    cs_n = 1'b1;
    repeat (2*H) @(negedge clk);
    chk(!so_oe_o, "R10", "SO released after deselect", {31'd0, so_oe_o}, 32'd0);
    chk(exp_cmd.size() == 0 && exp_step.size() == 0 && exp_rd.size() == 0, tag,
        "expected strobes missing", exp_cmd.size() + exp_step.size() + exp_rd.size(), 32'd0);
  endtask

  task automatic frame(input logic [7:0] b0, input logic [7:0] b1, input int nb,
                       input logic [7:0] b2, output logic [7:0] rx,
                       output logic oe_all, output logic oe_any);
    logic [7:0] dr;
    logic da, dy;
    cs_low();
    send_byte(b0, dr, da, dy);
    send_byte(b1, dr, da, dy);
    rx = 8'h00; oe_all = 1'b0; oe_any = 1'b0;
    if (nb > 2) send_byte(b2, rx, oe_all, oe_any);
    cs_high();
  endtask

  function automatic logic [7:0] id_byte(input logic [1:0] a);
    return {4'b0101, 2'b00, a};
  endfunction

  logic [7:0] rx;
  logic oa, oy, s0, o0;

  initial begin
    rst_n = 1'b0; sck = 1'b0; cs_n = 1'b0; si = 1'b0; hold_n = 1'b1; busy = 1'b0;
    addr = MY_ADDR;
    for (int c = 0; c < 4; c++) begin
      wiper_mem[c] = 6'(c * 9 + 4);
      for (int r = 0; r < 4; r++) dreg_mem[c][r] = 6'(c * 16 + r * 5 + 1);
    end
    repeat (3) @(negedge clk);
    chk(!so_oe_o && !cmd_stb_o && !step_stb_o && !rd_req_o, "R10", "reset outputs idle",
        {28'd0, so_oe_o, cmd_stb_o, step_stb_o, rd_req_o}, 32'd0);
    rst_n = 1'b1;
    wait_h();

    // R8: chip select low since reset, frame must be ignored
    tag = "R8";
    send_byte(id_byte(MY_ADDR), rx, oa, oy);
    send_byte(8'b1101_01_10, rx, oa, oy);
    cs_high();

    // R2: single and global copies
    tag = "R2";
    exp_cmd.push_back({3'd3, 2'd2, 2'd1, 6'd0});
    frame(id_byte(MY_ADDR), 8'b1101_01_10, 2, 8'h00, rx, oa, oy);
    exp_cmd.push_back({3'd4, 2'd0, 2'd2, 6'd0});
    frame(id_byte(MY_ADDR), 8'b1110_10_00, 2, 8'h00, rx, oa, oy);
    exp_cmd.push_back({3'd5, 2'd0, 2'd3, 6'd0});
    frame(id_byte(MY_ADDR), 8'b0001_11_00, 2, 8'h00, rx, oa, oy);
    exp_cmd.push_back({3'd6, 2'd0, 2'd1, 6'd0});
    frame(id_byte(MY_ADDR), 8'b1000_01_00, 2, 8'h00, rx, oa, oy);

    // R9: global copy with nonzero channel, undefined opcode
    tag = "R9";
    frame(id_byte(MY_ADDR), 8'b0001_10_01, 2, 8'h00, rx, oa, oy);
    frame(id_byte(MY_ADDR), 8'b0111_00_00, 3, 8'h3F, rx, oa, oy);
    chk(!oy, "R9", "SO undriven on undefined opcode", {31'd0, oy}, 32'd0);

    // R3: writes
    tag = "R3";
    exp_cmd.push_back({3'd1, 2'd1, 2'd0, 6'h2A});
    frame(id_byte(MY_ADDR), 8'b1010_00_01, 3, 8'h2A, rx, oa, oy);
    exp_cmd.push_back({3'd2, 2'd3, 2'd2, 6'h15});
    frame(id_byte(MY_ADDR), 8'b1100_10_11, 3, 8'hD5, rx, oa, oy);

    // R1: wrong address, wrong type
    tag = "R1";
    frame(id_byte(MY_ADDR ^ 2'b01), 8'b1101_00_00, 2, 8'h00, rx, oa, oy);
    frame(8'b0111_00_10, 8'b1011_00_00, 3, 8'h00, rx, oa, oy);
    chk(!oy, "R1", "SO undriven on ID mismatch", {31'd0, oy}, 32'd0);

    // R4: reads
    tag = "R4";
    exp_rd.push_back({1'b1, 2'd0, 2'd3});
    frame(id_byte(MY_ADDR), 8'b1011_11_00, 3, 8'h00, rx, oa, oy);
    chk(rx == {2'b00, dreg_mem[0][3]}, "R4", "data register read byte", {24'd0, rx},
        {26'd0, dreg_mem[0][3]});
    chk(oa, "R4", "SO driven for whole byte", {31'd0, oa}, 32'd1);
    exp_rd.push_back({1'b0, 2'd2, 2'd0});
    frame(id_byte(MY_ADDR), 8'b1001_00_10, 3, 8'hFF, rx, oa, oy);
    chk(rx == {2'b00, wiper_mem[2]}, "R4", "wiper read byte", {24'd0, rx},
        {26'd0, wiper_mem[2]});

    // R5: status
    tag = "R5";
    busy = 1'b1;
    frame(id_byte(MY_ADDR), 8'b0101_0001, 3, 8'h00, rx, oa, oy);
    chk(rx == 8'h01, "R5", "status busy", {24'd0, rx}, 32'd1);
    busy = 1'b0;
    frame(id_byte(MY_ADDR), 8'b0101_0001, 3, 8'h00, rx, oa, oy);
    chk(rx == 8'h00 && oa, "R5", "status idle", {23'd0, oa, rx}, 32'h100);

    // R6: stepping
    tag = "R6";
    cs_low();
    send_byte(id_byte(MY_ADDR), rx, oa, oy);
    send_byte(8'b0010_00_01, rx, oa, oy);
    for (int k = 0; k < 5; k++) begin
      logic b;
      b = (k == 2 || k == 4) ? 1'b0 : 1'b1;
      exp_step.push_back({b, 2'd1});
      xfer_bit(b, s0, o0);
    end
    cs_high();

    // R7: hold inside a write frame, extra SCK pulses ignored
    tag = "R7";
    exp_cmd.push_back({3'd2, 2'd2, 2'd1, 6'h0B});
    cs_low();
    send_byte(id_byte(MY_ADDR), rx, oa, oy);
    for (int i = 7; i >= 4; i--) xfer_bit(1'b1 ^ (i == 6 || i == 7 ? 1'b0 : 1'b1), s0, o0);
    wait_h();
    hold_n = 1'b0;
    wait_h();
    for (int k = 0; k < 2; k++) begin
      si = 1'b1; sck = 1'b1; wait_h(); sck = 1'b0; wait_h();
    end
    hold_n = 1'b1;
    wait_h();
    xfer_bit(1'b0, s0, o0); xfer_bit(1'b1, s0, o0);
    xfer_bit(1'b1, s0, o0); xfer_bit(1'b0, s0, o0);
    send_byte(8'h0B, rx, oa, oy);
    cs_high();

    // R7: hold inside a read frame releases SO
    exp_rd.push_back({1'b1, 2'd3, 2'd1});
    cs_low();
    send_byte(id_byte(MY_ADDR), rx, oa, oy);
    send_byte(8'b1011_01_11, rx, oa, oy);
    for (int i = 7; i >= 5; i--) begin xfer_bit(1'b0, s0, o0); rx[i] = s0; end
    wait_h();
    hold_n = 1'b0;
    wait_h();
    chk(!so_oe_o, "R7", "SO released in hold", {31'd0, so_oe_o}, 32'd0);
    hold_n = 1'b1;
    wait_h();
    chk(so_oe_o, "R7", "SO driven after resume", {31'd0, so_oe_o}, 32'd1);
    for (int i = 4; i >= 0; i--) begin xfer_bit(1'b0, s0, o0); rx[i] = s0; end
    chk(rx == {2'b00, dreg_mem[3][1]}, "R7", "read byte intact across hold", {24'd0, rx},
        {26'd0, dreg_mem[3][1]});
    cs_high();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule